// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block deserialises stereo PCM audio that arrives on a three-wire link: a bit clock, a word-select (frame) clock and a data line. A fast system clock samples all three wires. The block recovers each bit at the selected bit-clock edge and splits the stream into half-frames at word-select transitions. It presents each channel as a 24-bit two's-complement word. A single-cycle strobe marks every completed stereo frame.

A 3-bit format code selects how a sample sits inside its half-frame. The code chooses between LSB-justified words of 16, 20 or 24 bits, a 24-bit MSB-justified word, and the I2S arrangement. One configuration bit moves the latch edge to the falling bit-clock edge. Another swaps which word-select level means left. Software changes the polarity bits only while `enable` is low. While disabled, the block holds its outputs at zero.

Control is a four-state machine:

- **ST_OFF** idles while disabled. It goes to **ST_PRIME** when `enable` rises.
- **ST_PRIME** absorbs two latched bits so that the word-select history is valid. It then goes to **ST_ALIGN**.
- **ST_ALIGN** discards the partial half-frame in progress. At the first word-select transition it goes to **ST_RUN**.
- **ST_RUN** captures a word at every later transition.

Dropping `enable` returns any state to **ST_OFF**.

Top module: `audio_serial_rx`

## Requirements
- R1: With format code 3'b010, the sample MSB is the bit latched at the first bit-clock latch edge after a word-select transition. The next 23 bits follow MSB first, and bits after the 24th are ignored.
- R2: With format code 3'b011, the sample MSB is latched one bit clock after the word-select transition, and word-select low marks left. A ratio of exactly 32 bit clocks per frame is accepted.
- R3: With format codes 3'b000, 3'b001 and 3'b100, the last 16, 20 or 24 bits of a half-frame form the sample. Earlier bits are ignored, and the result is sign-extended to 24 bits.
- R4: LSB-justified capture works for any half-frame length from the format's minimum up to 64 bit clocks. The minimum is 16, 20 or 24 bit clocks.
- R5: In codes 3'b010 and 3'b011, a 16-bit or 20-bit word followed by zero bits yields the word left-justified in 24 bits. This is the same as a full 24-bit word with zero low bits.
- R6: In codes other than 3'b011, word-select high marks the left channel. Setting `ws_inv` swaps the channel assignment in every format.
- R7: With `bclk_inv` low, data is latched on the rising bit-clock edge. With `bclk_inv` high, data is latched on the falling edge.
- R8: `frame_strobe` is a one-cycle pulse, raised once per stereo frame after the right sample has been captured, with both sample outputs valid.
- R9: While `enable` is low, both samples read zero and no strobe is raised. After enabling, the first partial half-frame is discarded.
- R10: After reset, both samples read zero and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low clears and idles the block |
| fmt_sel | input | 3 | Framing format code |
| bclk_inv | input | 1 | 1 = latch on the falling bit-clock edge |
| ws_inv | input | 1 | 1 = swap the channel meaning of word-select |
| ser_bclk | input | 1 | Serial bit clock (asynchronous) |
| ser_ws | input | 1 | Serial word-select (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| left_sample | output | SMP_W | Left-channel sample, two's complement |
| right_sample | output | SMP_W | Right-channel sample, two's complement |
| frame_strobe | output | 1 | One-cycle pulse per completed stereo frame |

## Verification
The bench fills the don't-care leading slots of LSB-justified half-frames with ones. A design that kept stale bits or counted from the wrong end would return corrupted, unsign-extended values. I2S at 32 bit clocks per frame places the right LSB in the first slot of the next frame. A receiver that split half-frames at the raw word-select edge would lose that bit and swap channel data. Inverted polarities, zero-padded short words and a 128-clock frame each expose a missed edge, a shifted word or a channel swap. Traffic while disabled must produce no strobe and no output change.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'b000,
        FMT_LSB20 = 3'b001,
        FMT_MSB24 = 3'b010,
        FMT_I2S   = 3'b011,
        FMT_LSB24 = 3'b100
    } fmt_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_PRIME,
        ST_ALIGN,
        ST_RUN
    } rx_state_e;

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/asrx_slot_tracker.sv
module asrx_slot_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic ws_s,
    input  logic data_s,
    input  logic fall_edge,
    input  logic ws_delay,
    output logic bit_stb,
    output logic bit_val,
    output logic ws_eff
);

    logic bclk_q;
    logic ws_hist;
    logic latch;

    assign latch = fall_edge ? (bclk_q & ~bclk_s) : (~bclk_q & bclk_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            ws_hist <= 1'b0;
            bit_stb <= 1'b0;
            bit_val <= 1'b0;
            ws_eff  <= 1'b0;
        end else begin
            bclk_q  <= bclk_s;
            bit_stb <= latch;
            if (latch) begin
                bit_val <= data_s;
                ws_hist <= ws_s;
                ws_eff  <= ws_delay ? ws_hist : ws_s;
            end
        end
    end

    // R7
    latch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> ($past(bclk_s) == ~$past(fall_edge)));

endmodule

// File: rtl/asrx_word_pack.sv
module asrx_word_pack
    import asrx_pkg::*;
#(
    parameter int SMP_W = 24
) (
    input  logic [2:0]       fmt,
    input  logic [SMP_W-1:0] sr_lsb,
    input  logic [SMP_W-1:0] sr_msb,
    output logic [SMP_W-1:0] word
);

    localparam int SHORT_W = SMP_W - 8;
    localparam int MID_W   = SMP_W - 4;

    always_comb begin
        unique case (fmt_e'(fmt))
            FMT_LSB16: word = {{(SMP_W-SHORT_W){sr_lsb[SHORT_W-1]}}, sr_lsb[SHORT_W-1:0]};
            FMT_LSB20: word = {{(SMP_W-MID_W){sr_lsb[MID_W-1]}}, sr_lsb[MID_W-1:0]};
            FMT_LSB24: word = sr_lsb;
            default:   word = sr_msb;
        endcase
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int SMP_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       fmt_sel,
    input  logic             bclk_inv,
    input  logic             ws_inv,
    input  logic             ser_bclk,
    input  logic             ser_ws,
    input  logic             ser_data,
    output logic [SMP_W-1:0] left_sample,
    output logic [SMP_W-1:0] right_sample,
    output logic             frame_strobe
);

    localparam int CNT_W = $clog2(SMP_W + 1);

    logic [2:0]       sync_out;
    logic             bit_stb, bit_val, ws_eff;
    logic             i2s_mode;
    rx_state_e        state_q, state_nx;
    logic             ws_prev, prime_done, have_left;
    logic [SMP_W-1:0] sr_lsb, sr_msb, packed_word;
    logic [CNT_W-1:0] bit_cnt;
    logic             ws_change;
    logic             prev_is_left;

    assign i2s_mode     = (fmt_sel == FMT_I2S);
    assign ws_change    = (ws_eff != ws_prev);
    assign prev_is_left = ws_prev ^ i2s_mode ^ ws_inv;

    asrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_bclk, ser_ws, ser_data}),
        .dout  (sync_out)
    );

    asrx_slot_tracker tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (sync_out[2]),
        .ws_s      (sync_out[1]),
        .data_s    (sync_out[0]),
        .fall_edge (bclk_inv),
        .ws_delay  (i2s_mode),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .ws_eff    (ws_eff)
    );

    asrx_word_pack #(.SMP_W(SMP_W)) pack_i (
        .fmt    (fmt_sel),
        .sr_lsb (sr_lsb),
        .sr_msb (sr_msb),
        .word   (packed_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF:   if (enable) state_nx = ST_PRIME;
            ST_PRIME: if (bit_stb && prime_done) state_nx = ST_ALIGN;
            ST_ALIGN: if (bit_stb && ws_change) state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_OFF;
        endcase
        if (!enable) state_nx = ST_OFF;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev      <= 1'b0;
            prime_done   <= 1'b0;
            have_left    <= 1'b0;
            sr_lsb       <= '0;
            sr_msb       <= '0;
            bit_cnt      <= '0;
            left_sample  <= '0;
            right_sample <= '0;
            frame_strobe <= 1'b0;
        end else begin
            frame_strobe <= 1'b0;
            if (!enable || state_q == ST_OFF) begin
                prime_done   <= 1'b0;
                have_left    <= 1'b0;
                sr_lsb       <= '0;
                sr_msb       <= '0;
                bit_cnt      <= '0;
                left_sample  <= '0;
                right_sample <= '0;
            end else if (bit_stb) begin
                ws_prev    <= ws_eff;
                prime_done <= 1'b1;
                sr_lsb     <= {sr_lsb[SMP_W-2:0], bit_val};
                if (state_q == ST_RUN && ws_change) begin
                    if (prev_is_left) begin
                        left_sample <= packed_word;
                        have_left   <= 1'b1;
                    end else begin
                        right_sample <= packed_word;
                        have_left    <= 1'b0;
                        frame_strobe <= have_left;
                    end
                end
                if (ws_change) begin
                    sr_msb  <= {bit_val, {(SMP_W-1){1'b0}}};
                    bit_cnt <= CNT_W'(1);
                end else if (bit_cnt < CNT_W'(SMP_W)) begin
                    sr_msb[CNT_W'(SMP_W-1) - bit_cnt] <= bit_val;
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);

    // R8
    strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> ($past(state_q) == ST_RUN));

    // R9
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (left_sample == '0 && right_sample == '0 && !frame_strobe));

    // R9
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> ($past(state_q) == ST_ALIGN));

endmodule

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  fmt_sel = 3'b010;
    logic        bclk_inv = 1'b0;
    logic        ws_inv = 1'b0;
    logic        ser_bclk = 1'b0;
    logic        ser_ws = 1'b0;
    logic        ser_data = 1'b0;
    logic [23:0] left_sample, right_sample;
    logic        frame_strobe;

    int total = 0;
    int bad = 0;
    int ncap = 0;
    int wide_err = 0;
    logic strobe_prev = 1'b0;
    logic carry = 1'b0;
    logic [23:0] cap_l [8];
    logic [23:0] cap_r [8];
    logic [23:0] tl [3];
    logic [23:0] tr [3];

    always #4 clk = ~clk;

    audio_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt_sel(fmt_sel),
        .bclk_inv(bclk_inv), .ws_inv(ws_inv), .ser_bclk(ser_bclk),
        .ser_ws(ser_ws), .ser_data(ser_data), .left_sample(left_sample),
        .right_sample(right_sample), .frame_strobe(frame_strobe)
    );

    always @(negedge clk) begin
        if (frame_strobe) begin
            if (ncap < 8) begin
                cap_l[ncap] = left_sample;
                cap_r[ncap] = right_sample;
            end
            ncap++;
        end
        if (frame_strobe && strobe_prev) wide_err++;
        strobe_prev = frame_strobe;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lsb_n(input logic [2:0] f);
        case (f)
            3'b000:  return 16;
            3'b001:  return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic is_msb_fmt(input logic [2:0] f);
        return (f == 3'b010) || (f == 3'b011);
    endfunction

    function automatic logic [23:0] exp_val(input logic [2:0] f, input int w, input logic [23:0] v);
        logic [23:0] t;
        int n;
        if (is_msb_fmt(f)) begin
            t = v << (24 - w);
            return t;
        end
        n = lsb_n(f);
        t = v << (24 - n);
        return $signed(t) >>> (24 - n);
    endfunction

    function automatic logic slot_bit(input logic [2:0] f, input int h, input int w,
                                      input logic [23:0] v, input int s);
        int n;
        if (is_msb_fmt(f)) return (s < w) ? v[w-1-s] : 1'b0;
        n = lsb_n(f);
        return (s >= h - n) ? v[h-1-s] : 1'b1;
    endfunction

    task automatic slot(input logic w, input logic d);
        ser_ws   = w;
        ser_data = d;
        wait_cyc(4);
        ser_bclk = ~bclk_inv;
        wait_cyc(4);
        ser_bclk = bclk_inv;
    endtask

    task automatic send_frame(input int h, input int w, input logic [23:0] lv, input logic [23:0] rv);
        logic i2s;
        logic left_lvl;
        i2s = (fmt_sel == 3'b011);
        left_lvl = (i2s ? 1'b0 : 1'b1) ^ ws_inv;
        for (int half = 0; half < 2; half++) begin
            for (int s = 0; s < h; s++) begin
                logic b;
                b = slot_bit(fmt_sel, h, w, (half == 0) ? lv : rv, s);
                if (i2s) begin
                    slot((half == 0) ? left_lvl : ~left_lvl, carry);
                    carry = b;
                end else begin
                    slot((half == 0) ? left_lvl : ~left_lvl, b);
                end
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [2:0] f, input logic binv,
                            input logic winv, input int h, input int w);
        enable = 1'b0;
        wait_cyc(4);
        fmt_sel  = f;
        bclk_inv = binv;
        ws_inv   = winv;
        ser_bclk = binv;
        ser_ws   = ((f == 3'b011) ? 1'b1 : 1'b0) ^ winv;
        wait_cyc(8);
        enable = 1'b1;
        wait_cyc(4);
        ncap  = 0;
        carry = 1'b0;
        send_frame(h, w, 24'h0, 24'h0);
        for (int k = 0; k < 3; k++) send_frame(h, w, tl[k], tr[k]);
        send_frame(h, w, 24'h0, 24'h0);
        wait_cyc(16);
        chk_int({tag, " frame count"}, ncap, 3);
        for (int k = 0; k < 3; k++) begin
            chk({tag, " left"},  cap_l[k], exp_val(f, w, tl[k]));
            chk({tag, " right"}, cap_r[k], exp_val(f, w, tr[k]));
        end
    endtask

    task automatic test_reset;
        chk("R10 left after reset", left_sample, 24'h0);
        chk("R10 right after reset", right_sample, 24'h0);
        chk_int("R10 strobe after reset", int'(frame_strobe), 0);
    endtask

    task automatic test_msb24;
        tl = '{24'h123456, 24'h800001, 24'h0F0F0F};
        tr = '{24'hABCDEF, 24'h000001, 24'hFFFFFE};
        run_case("R1 msb24 32/half", 3'b010, 1'b0, 1'b0, 32, 24);
        run_case("R1 msb24 24/half", 3'b010, 1'b0, 1'b0, 24, 24);
    endtask

    task automatic test_pad;
        tl = '{24'h00A5C3, 24'h008000, 24'h007FFF};
        tr = '{24'h00FFFF, 24'h001234, 24'h000001};
        run_case("R5 msb 16+pad", 3'b010, 1'b0, 1'b0, 32, 16);
        tl = '{24'h0ABCDE, 24'h080000, 24'h07FFFF};
        tr = '{24'h0FFFFF, 24'h012345, 24'h000010};
        run_case("R5 msb 20+pad", 3'b010, 1'b0, 1'b0, 32, 20);
    endtask

    task automatic test_i2s;
        tl = '{24'h13579B, 24'hFEDCBA, 24'h400000};
        tr = '{24'h2468AC, 24'h000003, 24'hC00000};
        run_case("R2 i2s 32/half", 3'b011, 1'b0, 1'b0, 32, 24);
        tl = '{24'h00BEEF, 24'h008001, 24'h000001};
        tr = '{24'h00CAFE, 24'h007FFE, 24'h008000};
        run_case("R2 R5 i2s 32fs", 3'b011, 1'b0, 1'b0, 16, 16);
    endtask

    task automatic test_lsb;
        tl = '{24'hFF8001, 24'h007FFF, 24'hAA1234};
        tr = '{24'h00FFFF, 24'h550001, 24'h00C000};
        run_case("R3 lsb16 32fs", 3'b000, 1'b0, 1'b0, 16, 16);
        run_case("R3 R4 lsb16 128fs", 3'b000, 1'b0, 1'b0, 64, 16);
        tl = '{24'hF80001, 24'h07FFFF, 24'h0A5A5A};
        tr = '{24'h0FFFFF, 24'h180000, 24'h000123};
        run_case("R3 R4 lsb20 40fs", 3'b001, 1'b0, 1'b0, 20, 20);
        tl = '{24'h800000, 24'h7FFFFF, 24'h3C3C3C};
        tr = '{24'hFFFFFF, 24'h000001, 24'hC3C3C3};
        run_case("R3 R4 lsb24 48fs", 3'b100, 1'b0, 1'b0, 24, 24);
        run_case("R3 R4 lsb24 128fs", 3'b100, 1'b0, 1'b0, 64, 24);
    endtask

    task automatic test_ws_inv;
        tl = '{24'h111111, 24'h222222, 24'h333333};
        tr = '{24'hEEEEEE, 24'hDDDDDD, 24'hCCCCCC};
        run_case("R6 ws_inv msb24", 3'b010, 1'b0, 1'b1, 32, 24);
        run_case("R6 ws_inv i2s", 3'b011, 1'b0, 1'b1, 32, 24);
    endtask

    task automatic test_bclk_inv;
        tl = '{24'h5A5A5A, 24'hA5A5A5, 24'h00F00F};
        tr = '{24'h0F0F0F, 24'hF0F0F0, 24'h800000};
        run_case("R7 falling latch msb24", 3'b010, 1'b1, 1'b0, 24, 24);
        run_case("R7 falling latch lsb16", 3'b000, 1'b1, 1'b0, 32, 16);
    endtask

    task automatic test_disabled;
        enable = 1'b0;
        fmt_sel = 3'b010;
        bclk_inv = 1'b0;
        ws_inv = 1'b0;
        ser_bclk = 1'b0;
        wait_cyc(8);
        ncap = 0;
        for (int k = 0; k < 3; k++) send_frame(32, 24, 24'h7A7A7A, 24'h656565);
        wait_cyc(16);
        chk_int("R9 no strobe when disabled", ncap, 0);
        chk("R9 left idle when disabled", left_sample, 24'h0);
        chk("R9 right idle when disabled", right_sample, 24'h0);
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(3);
        test_reset();
        test_msb24();
        test_pad();
        test_i2s();
        test_lsb();
        test_ws_inv();
        test_bclk_inv();
        test_disabled();
        chk_int("R8 strobe width", wide_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule